// File: doc/BRIEF.md
# Trapezoidal Ringing Waveform Generator

This block produces a trapezoidal ringing signal as a stream of signed 16-bit samples, one per 8 kHz sample strobe. While enabled, the internal waveform value moves by a programmed step on each strobe toward the positive or negative amplitude limit. It stops exactly at the limit and holds there until the polarity reverses. The polarity reverses after a fixed number of strobes, which software sets through a period value held in quarter-sample units.

The cadence controller drives the enable input, so ring bursts follow the same on/off timing used for sinusoidal ringing. A signed DC offset, shared with the sinusoidal path, is added to the clamped value, and the result saturates to the 16-bit range. Software works out the step, limit and period from the wanted peak voltage, frequency and crest factor. For example, a 20 Hz, 90 V peak waveform uses period 1600, limit 18340 and step 300.

Top module: `trap_ring_gen`

## Requirements
- R1: After reset, `sample_o` is 0 and `valid_o` is 0.
- R2: `valid_o` is high for exactly the one clock cycle that follows each cycle in which `tick_i` is high, and is low at all other times.
- R3: On the first strobe after `en_i` rises, the waveform starts from 0 heading positive. Each strobe moves it by `step_i` in the current direction.
- R4: The waveform never passes `+amp_i` or `-amp_i`. A step that would pass the limit lands exactly on the limit, and later steps in that direction hold it there.
- R5: Let half = `period_i` >> 3. The direction changes after every half strobes counted since enable, so strobes 0..half-1 go positive and the next half go negative. When half is 0, the direction never changes.
- R6: While `en_i` is low, the waveform is forced to 0, the strobe count is cleared and the direction returns to positive. A strobe then outputs the offset alone.
- R7: `sample_o` equals the waveform value after clamping plus `offset_i`, saturated to the range -32768..32767.
- R8: `sample_o` changes only in the cycle after a strobe and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 8 kHz sample strobe, one cycle wide |
| en_i | input | 1 | Ringing enable from the cadence controller |
| step_i | input | 15 | Ramp step per sample, unsigned |
| amp_i | input | 15 | Amplitude limit, unsigned |
| period_i | input | 16 | Period in quarter-sample units |
| offset_i | input | 16 | Signed DC offset |
| sample_o | output | 16 | Signed output sample |
| valid_o | output | 1 | Sample strobe, one cycle after `tick_i` |

## Verification
The main coincidence is a polarity reversal that falls on the same strobe where the ramp reaches or leaves a limit. With half values of 1 and 3 and steps much larger than the limit, the waveform clamps on the first strobe and reverses on the next one. The bench checks that the reversal uses the new direction and does not skip or repeat a clamped sample. A second overlap comes from offsets at the extremes of the range, which push clamped peaks into output saturation. There the bench checks that clamping is applied before the offset is added, and saturation after.

// File: rtl/trap_pkg.sv
package trap_pkg;
  parameter int unsigned SAMPLE_W = 16;
  parameter int unsigned PERIOD_W = 16;
  parameter int unsigned QUARTER_SHIFT = 3;

  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;
endpackage

// File: rtl/trap_half_timer.sv
module trap_half_timer #(
  parameter int unsigned PW = trap_pkg::PERIOD_W,
  parameter int unsigned SHIFT = trap_pkg::QUARTER_SHIFT
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           en_i,
  input  logic [PW-1:0]  period_i,
  output trap_pkg::dir_e dir_o
);
  import trap_pkg::*;

  logic [PW-1:0] half, cnt_q;
  dir_e          dir_q;

  assign half  = period_i >> SHIFT;
  assign dir_o = dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (!en_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick_i && half != '0) begin
      if (cnt_q >= half - 1'b1) begin
        cnt_q <= '0;
        dir_q <= (dir_q == DIR_UP) ? DIR_DN : DIR_UP;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_FLIP_AT_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && half != '0 && cnt_q == half - 1'b1) |=> (dir_q != $past(dir_q))); // R5
  AST_DIR_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> ($stable(dir_q) && $stable(cnt_q))); // R5
  AST_DIR_RESET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (dir_q == DIR_UP && cnt_q == '0)); // R6
endmodule

// File: rtl/trap_ramp.sv
module trap_ramp #(
  parameter int unsigned DW = trap_pkg::SAMPLE_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  tick_i,
  input  logic                  en_i,
  input  trap_pkg::dir_e        dir_i,
  input  logic [DW-2:0]         step_i,
  input  logic [DW-2:0]         amp_i,
  output logic signed [DW:0]    wave_nxt_o
);
  import trap_pkg::*;

  localparam int unsigned EW = DW + 2;

  logic signed [DW:0]   wave_q;
  logic signed [EW-1:0] wave_ext, amp_s, step_s, up, dn, nxt;

  assign wave_ext = {wave_q[DW], wave_q};
  assign amp_s    = signed'({3'b000, amp_i});
  assign step_s   = signed'({3'b000, step_i});
  assign up       = wave_ext + step_s;
  assign dn       = wave_ext - step_s;

  always_comb begin
    if (dir_i == DIR_UP) nxt = (up > amp_s) ? amp_s : up;
    else                 nxt = (dn < -amp_s) ? -amp_s : dn;
  end

  // value presented with the strobe; forced to zero while off
  assign wave_nxt_o = en_i ? nxt[DW:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             wave_q <= '0;
    else if (!en_i)          wave_q <= '0;
    else if (tick_i)         wave_q <= nxt[DW:0];
  end

  AST_SLEW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && wave_ext <= amp_s && wave_ext >= -amp_s)
      |=> ((wave_ext - $past(wave_ext)) <= $past(step_s)
        && ($past(wave_ext) - wave_ext) <= $past(step_s))); // R3
  AST_WITHIN_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i && $stable(amp_s) && wave_ext <= amp_s && wave_ext >= -amp_s)
      |=> (wave_ext <= amp_s && wave_ext >= -amp_s)); // R4
  AST_ZERO_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (wave_q == '0)); // R6
endmodule

// File: rtl/trap_ring_gen.sv
module trap_ring_gen #(
  parameter int unsigned DW = trap_pkg::SAMPLE_W,
  parameter int unsigned PW = trap_pkg::PERIOD_W,
  parameter int unsigned SHIFT = trap_pkg::QUARTER_SHIFT
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 en_i,
  input  logic [DW-2:0]        step_i,
  input  logic [DW-2:0]        amp_i,
  input  logic [PW-1:0]        period_i,
  input  logic signed [DW-1:0] offset_i,
  output logic signed [DW-1:0] sample_o,
  output logic                 valid_o
);
  import trap_pkg::*;

  localparam int unsigned EW = DW + 2;
  localparam logic signed [EW-1:0] MAX_V = signed'({3'b000, {(DW-1){1'b1}}});
  localparam logic signed [EW-1:0] MIN_V = signed'({3'b111, {(DW-1){1'b0}}});

  dir_e                 dir;
  logic signed [DW:0]   wave_nxt;
  logic signed [EW-1:0] sum;
  logic signed [DW-1:0] sample_d;

  trap_half_timer #(.PW(PW), .SHIFT(SHIFT)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .en_i     (en_i),
    .period_i (period_i),
    .dir_o    (dir)
  );

  trap_ramp #(.DW(DW)) u_ramp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (en_i),
    .dir_i      (dir),
    .step_i     (step_i),
    .amp_i      (amp_i),
    .wave_nxt_o (wave_nxt)
  );

  // offset after clamp, then saturate
  assign sum = {wave_nxt[DW], wave_nxt} + {{2{offset_i[DW-1]}}, offset_i};

  always_comb begin
    if (sum > MAX_V)      sample_d = MAX_V[DW-1:0];
    else if (sum < MIN_V) sample_d = MIN_V[DW-1:0];
    else                  sample_d = sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= tick_i;
      if (tick_i) sample_o <= sample_d;
    end
  end

  AST_VALID_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> valid_o); // R2
  AST_NO_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> !valid_o); // R2
  AST_HOLD_BETWEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sample_o)); // R8
  AST_OFFSET_ONLY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !en_i) |=> (sample_o == $past(offset_i))); // R6
endmodule

// File: tb/sim_trap_ring_gen.sv
module sim_trap_ring_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic [14:0] step = '0;
  logic [14:0] amp = '0;
  logic [15:0] period = '0;
  logic signed [15:0] offset = '0;
  logic signed [15:0] sample;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_wave = 0;
  int m_dir = 0;
  int m_cnt = 0;
  bit m_flipped = 0;

  always #10 clk = ~clk;

  trap_ring_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .en_i(en),
    .step_i(step), .amp_i(amp), .period_i(period), .offset_i(offset),
    .sample_o(sample), .valid_o(valid)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_off();
    m_wave = 0; m_dir = 0; m_cnt = 0; m_flipped = 0;
  endtask

  // one strobe: apply, then compare strobe cycle and the quiet cycle after it
  task automatic do_tick();
    int half, sum, exp_s, a, s;
    string tag;
    bit sat;
    bit flip_prev;
    a = int'(amp); s = int'(step);
    flip_prev = m_flipped;
    m_flipped = 0;
    if (!en) begin
      m_wave = 0;
    end else begin
      if (m_dir == 0) m_wave = (m_wave + s > a) ? a : m_wave + s;
      else            m_wave = (m_wave - s < -a) ? -a : m_wave - s;
      half = int'(period) >> 3;
      if (half != 0) begin
        if (m_cnt >= half - 1) begin m_cnt = 0; m_dir ^= 1; m_flipped = 1; end
        else m_cnt++;
      end
    end
    sum = m_wave + int'(offset);
    sat = 0;
    exp_s = sum;
    if (sum > 32767) begin exp_s = 32767; sat = 1; end
    if (sum < -32768) begin exp_s = -32768; sat = 1; end
    if (!en)                             tag = "R6";
    else if (sat)                        tag = "R7";
    else if (flip_prev)                  tag = "R5";
    else if (m_wave == a || m_wave == -a) tag = "R4";
    else                                 tag = "R3";
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    check("R2 valid on strobe", int'(valid), 1);
    check(tag, int'(sample), exp_s);
    @(negedge clk);
    check("R2 valid idle", int'(valid), 0);
    check("R8 sample held", int'(sample), exp_s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 sample reset", int'(sample), 0);
    check("R1 valid reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    foreach (amp_tab[i]) foreach (step_tab[j]) foreach (per_tab[k]) foreach (off_tab[l]) begin
      en = 1'b0;
      amp = amp_tab[i]; step = step_tab[j]; period = per_tab[k]; offset = off_tab[l];
      @(negedge clk);
      model_off();
      do_tick(); // R6 offset only while off
      en = 1'b1;
      for (int n = 0; n < 30; n++) do_tick();
      en = 1'b0;
      @(negedge clk);
      model_off();
      do_tick();
    end

    // 20 Hz, 90 V peak example: period 1600, limit 18340, step 300
    amp = 15'd18340; step = 15'd300; period = 16'd1600; offset = 16'sd0;
    @(negedge clk);
    en = 1'b1;
    for (int n = 0; n < 450; n++) do_tick();
    en = 1'b0;
    @(negedge clk);
    model_off();
    do_tick();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  logic [14:0] amp_tab [4] = '{15'd0, 15'd5, 15'd100, 15'd32767};
  logic [14:0] step_tab [4] = '{15'd1, 15'd7, 15'd300, 15'd32767};
  logic [15:0] per_tab [4] = '{16'd0, 16'd8, 16'd24, 16'd64};
  logic signed [15:0] off_tab [4] = '{16'sd0, 16'sd1000, -16'sd32768, 16'sd32767};

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end
endmodule